// File: doc/BRIEF.md
# Asynchronous Host Bus Slave with Wait Stretching

This block connects an external microcontroller, clocked independently of the chip, to an internal register file. The host drives active-low chip-select, read and write strobes, plus an address-latch strobe. A mode pin selects one of two address schemes. In multiplexed mode the low address byte shares the data lines and is captured when the latch strobe falls. In separate mode a dedicated nine-bit address input is used.

A width pin decides whether the upper data byte takes part in transfers. Every host strobe passes through a synchroniser before the core logic acts on it. The block raises an active-high wait output for a programmable number of core cycles on every access. Accesses whose address bit 8 is set get a much longer wait, which covers a shadow-register transfer.

In multiplexed mode the address byte is also presented on a demultiplexed address output, which behaves as a transparent latch. On the register side the block offers an address, a one-cycle read pulse, a one-cycle write pulse with data, and a read-data input.

Top module: `hostbus_slave`

## Requirements
- R1: An access starts only when the synchronised chip-select and at least one synchronised strobe (read or write) are both low, so the start follows whichever of them falls later. Chip-select low with both strobes high, or a strobe low with chip-select high, produces no wait and no register read pulse.
- R2: With `mux_mode_i` high, the register address is {`addr_i[8]`, `ad_lo_i`}, captured when the synchronised latch strobe falls. With `mux_mode_i` low, the address is `addr_i` taken at access start. The address holds steady while `wait_o` is high.
- R3: With `mux_mode_i` high, `demux_addr_o` follows `ad_lo_i` at once while `ale_i` is high, and keeps the last value after `ale_i` falls until `ale_i` rises again. With `mux_mode_i` low, it shows `addr_i[7:0]`.
- R4: Every access with address bit 8 clear holds `wait_o` high for exactly BASE_WAIT core cycles (default 2).
- R5: Every access with address bit 8 set holds `wait_o` high for exactly SHADOW_WAIT core cycles (default 12), and never longer.
- R6: During a read, `ad_lo_o` returns the register-file word at the latched address. `ad_lo_oe` is high only while raw `cs_n_i` and `rd_n_i` are both low, and it drops combinationally when either one rises.
- R7: With `wide_mode_i` low, `ad_hi_oe` stays low on reads and the upper byte of a write is zero. With `wide_mode_i` high, both bytes are transferred.
- R8: A write produces exactly one single-cycle `reg_we_o` pulse, after the synchronised write strobe or chip-select rises. It carries the bus data sampled during the strobe and the latched address, and it never occurs while a read is live.
- R9: In separate mode, when chip-select and read are held low after a read whose bit 8 was set, a new `addr_i[7:0]` returns fresh data within a few cycles, with bit 8 kept. After a read with bit 8 clear, an address change has no effect on the returned data.
- R10: While reset is held and immediately after it, `wait_o`, `ad_lo_oe`, `ad_hi_oe`, `reg_we_o` and `reg_re_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_mode_i | input | 1 | 1: address on shared lines, 0: separate address |
| wide_mode_i | input | 1 | 1: 16-bit data, 0: 8-bit data |
| cs_n_i | input | 1 | Host chip-select, active low, asynchronous |
| rd_n_i | input | 1 | Host read strobe, active low, asynchronous |
| wr_n_i | input | 1 | Host write strobe, active low, asynchronous |
| ale_i | input | 1 | Host address-latch strobe (held low in separate mode) |
| addr_i | input | 9 | Separate address; bit 8 also used in multiplexed mode |
| ad_lo_i | input | 8 | Low byte of shared address/data lines, input side |
| ad_hi_i | input | 8 | High data byte, input side |
| ad_lo_o | output | 8 | Low read-data byte |
| ad_hi_o | output | 8 | High read-data byte |
| ad_lo_oe | output | 1 | Output enable for the low byte |
| ad_hi_oe | output | 1 | Output enable for the high byte |
| demux_addr_o | output | 8 | Demultiplexed address byte |
| wait_o | output | 1 | Active-high cycle extension request |
| reg_addr_o | output | 9 | Register-file address |
| reg_re_o | output | 1 | One-cycle read pulse at read start |
| reg_we_o | output | 1 | One-cycle write pulse |
| reg_wdata_o | output | 16 | Write data |
| reg_rdata_i | input | 16 | Register-file read data |

## Verification
A latched address that is wrong or that drifts shows up as wrong read data on `ad_lo_o` about two core cycles after the access begins, long before the host releases its strobes. A bad wait counter shows as a wait pulse whose length differs from BASE_WAIT or SHADOW_WAIT, and this is visible within the first dozen cycles of the access. A broken active-access tracker shows at the write port as a missing or doubled `reg_we_o` pulse about three cycles after the strobe rises, or at the bus as an output enable that stays on after release. A stale shadow flag shows as frozen or wrongly updated data during an extended read, two cycles after the address changes.

// File: rtl/hostbus_slave.sv
module hostbus_slave #(
  parameter int BASE_WAIT   = 2,
  parameter int SHADOW_WAIT = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mux_mode_i,
  input  logic        wide_mode_i,
  input  logic        cs_n_i,
  input  logic        rd_n_i,
  input  logic        wr_n_i,
  input  logic        ale_i,
  input  logic [8:0]  addr_i,
  input  logic [7:0]  ad_lo_i,
  input  logic [7:0]  ad_hi_i,
  output logic [7:0]  ad_lo_o,
  output logic [7:0]  ad_hi_o,
  output logic        ad_lo_oe,
  output logic        ad_hi_oe,
  output logic [7:0]  demux_addr_o,
  output logic        wait_o,
  output logic [8:0]  reg_addr_o,
  output logic        reg_re_o,
  output logic        reg_we_o,
  output logic [15:0] reg_wdata_o,
  input  logic [15:0] reg_rdata_i
);
  localparam int CW = $clog2(SHADOW_WAIT + 1);
  localparam logic [3:0] IDLE_PINS = 4'b0111;

  // synchroniser: bit3 ale, bit2 wr_n, bit1 rd_n, bit0 cs_n
  logic [3:0] sync_q [SYNC_STAGES];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= IDLE_PINS;
    else begin
      sync_q[0] <= {ale_i, wr_n_i, rd_n_i, cs_n_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end

  logic cs_on, rd_on, wr_on, ale_s;
  assign cs_on = ~sync_q[SYNC_STAGES-1][0];
  assign rd_on = ~sync_q[SYNC_STAGES-1][1];
  assign wr_on = ~sync_q[SYNC_STAGES-1][2];
  assign ale_s =  sync_q[SYNC_STAGES-1][3];

  logic act, act_q, start, done, ale_q, ale_fall;
  logic is_rd_q, rd_live, shadow_q, ext_ok;
  logic [CW-1:0] cnt;
  logic [7:0]  held_ad;
  logic [15:0] rdata_q, wdata_q;
  logic        start_bit8;

  assign act        = cs_on & (rd_on | wr_on);
  assign start      = act & ~act_q;
  assign done       = ~act & act_q;
  assign ale_fall   = mux_mode_i & ale_q & ~ale_s;
  assign start_bit8 = mux_mode_i ? reg_addr_o[8] : addr_i[8];
  assign ext_ok     = rd_live & shadow_q & ~mux_mode_i & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_q <= 1'b0; ale_q <= 1'b0; is_rd_q <= 1'b0; rd_live <= 1'b0;
      shadow_q <= 1'b0; cnt <= '0; reg_re_o <= 1'b0; reg_we_o <= 1'b0;
    end else begin
      act_q    <= act;
      ale_q    <= ale_s;
      reg_re_o <= start & rd_on;
      reg_we_o <= done & ~is_rd_q;
      if (start) begin
        is_rd_q  <= rd_on;
        shadow_q <= start_bit8 & rd_on;
        cnt      <= start_bit8 ? CW'(SHADOW_WAIT) : CW'(BASE_WAIT);
      end else if (cnt != '0) cnt <= cnt - 1'b1;
      if (start & rd_on) rd_live <= 1'b1;
      else if (!act)     rd_live <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      held_ad <= '0; reg_addr_o <= '0; rdata_q <= '0; wdata_q <= '0;
    end else begin
      if (mux_mode_i && ale_s) held_ad <= ad_lo_i;
      if (ale_fall)                    reg_addr_o <= {addr_i[8], held_ad};
      else if (start && !mux_mode_i)   reg_addr_o <= addr_i;
      else if (ext_ok)                 reg_addr_o[7:0] <= addr_i[7:0];
      if (rd_live) rdata_q <= reg_rdata_i;
      if (act && wr_on && !is_rd_q && !start)
        wdata_q <= {wide_mode_i ? ad_hi_i : 8'h00, ad_lo_i};
    end

  assign wait_o       = (cnt != '0);
  assign ad_lo_o      = rdata_q[7:0];
  assign ad_hi_o      = rdata_q[15:8];
  assign ad_lo_oe     = ~cs_n_i & ~rd_n_i & rd_live;
  assign ad_hi_oe     = ad_lo_oe & wide_mode_i;
  assign reg_wdata_o  = wdata_q;
  assign demux_addr_o = !mux_mode_i ? addr_i[7:0] : (ale_i ? ad_lo_i : held_ad);

  p_we_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);
  p_we_not_reading_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> !ad_lo_oe);
  p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(SHADOW_WAIT));
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_o && $past(wait_o)) |-> $stable(reg_addr_o));
  p_re_at_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re_o |-> wait_o);
endmodule

// File: tb/hostbus_slave_tb.sv
module hostbus_slave_tb_top;
  localparam int BW = 2, SW = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mux_mode_i = 0, wide_mode_i = 1, cs_n_i = 1, rd_n_i = 1, wr_n_i = 1, ale_i = 0;
  logic [8:0] addr_i = '0;
  logic [7:0] ad_lo_i = '0, ad_hi_i = '0;
  logic [7:0] ad_lo_o, ad_hi_o, demux_addr_o;
  logic ad_lo_oe, ad_hi_oe, wait_o, reg_re_o, reg_we_o;
  logic [8:0] reg_addr_o;
  logic [15:0] reg_wdata_o, reg_rdata_i;
  logic [15:0] rf [512];
  logic [15:0] exp_mem [512];
  int checks = 0, fails = 0, we_cnt = 0, re_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hostbus_slave #(.BASE_WAIT(BW), .SHADOW_WAIT(SW)) dut_i (.*);

  assign reg_rdata_i = rf[reg_addr_o];
  always @(posedge clk) begin
    if (reg_we_o) rf[reg_addr_o] <= reg_wdata_o;
    if (reg_we_o) we_cnt <= we_cnt + 1;
    if (reg_re_o) re_cnt <= re_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // {mux, wide, write, addr[8:0], data[15:0]}
  localparam logic [27:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b1, 9'h012, 16'hBEEF},
    {1'b0, 1'b1, 1'b0, 9'h012, 16'h0000},
    {1'b1, 1'b1, 1'b1, 9'h1A3, 16'h1234},
    {1'b1, 1'b1, 1'b0, 9'h1A3, 16'h0000},
    {1'b0, 1'b0, 1'b1, 9'h044, 16'h77AA},
    {1'b0, 1'b1, 1'b0, 9'h044, 16'h0000},
    {1'b1, 1'b0, 1'b0, 9'h0C0, 16'h0000},
    {1'b0, 1'b1, 1'b0, 9'h1FF, 16'h0000}
  };

  task automatic access(input bit mux, input bit wide, input bit wr, input logic [8:0] a,
                        input logic [15:0] d, output int wlen, output logic [15:0] rdat,
                        output bit oe_lo, output bit oe_hi);
    mux_mode_i = mux; wide_mode_i = wide; wlen = 0;
    if (mux) begin
      addr_i = {a[8], 8'h00}; ad_lo_i = a[7:0]; ale_i = 1;
      repeat (2) @(negedge clk);
      ale_i = 0;
      repeat (4) @(negedge clk);
    end else begin
      addr_i = a;
      @(negedge clk);
    end
    if (wr) begin
      ad_lo_i = d[7:0]; ad_hi_i = d[15:8]; cs_n_i = 0; wr_n_i = 0;
    end else begin
      cs_n_i = 0; rd_n_i = 0;
    end
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (wait_o) wlen++;
    end
    rdat = {ad_hi_o, ad_lo_o}; oe_lo = ad_lo_oe; oe_hi = ad_hi_oe;
    cs_n_i = 1; rd_n_i = 1; wr_n_i = 1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    int wl, we0, re0;
    logic [15:0] rd;
    bit ol, oh;
    for (int i = 0; i < 512; i++) begin
      rf[i] = 16'(i * 291) ^ 16'hA5C3;
      exp_mem[i] = 16'(i * 291) ^ 16'hA5C3;
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({wait_o, ad_lo_oe, ad_hi_oe, reg_we_o, reg_re_o} == 5'b0, "R10 in reset",
        {wait_o, ad_lo_oe, ad_hi_oe, reg_we_o, reg_re_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({wait_o, ad_lo_oe, reg_we_o, reg_re_o} == 4'b0, "R10 after reset",
        {wait_o, ad_lo_oe, reg_we_o, reg_re_o}, 0);

    foreach (VEC[k]) begin
      logic [8:0] a = VEC[k][24:16];
      logic [15:0] d = VEC[k][15:0];
      bit mux = VEC[k][27], wide = VEC[k][26], wr = VEC[k][25];
      we0 = we_cnt;
      access(mux, wide, wr, a, d, wl, rd, ol, oh);
      chk(wl == (a[8] ? SW : BW), a[8] ? "R5 shadow wait" : "R4 base wait", wl, a[8] ? SW : BW);
      if (wr) begin
        exp_mem[a] = wide ? d : {8'h00, d[7:0]};
        chk(we_cnt - we0 == 1, "R8 one write pulse", we_cnt - we0, 1);
      end else begin
        chk(we_cnt == we0, "R8 no write on read", we_cnt - we0, 0);
        chk(ol == 1, "R6 low byte enabled", ol, 1);
        chk(oh == wide, "R7 high byte enable", oh, wide);
        if (wide) chk(rd == exp_mem[a], mux ? "R2 R6 mux read" : "R6 read", rd, exp_mem[a]);
        else      chk(rd[7:0] == exp_mem[a][7:0], "R7 narrow read", rd[7:0], exp_mem[a][7:0]);
        chk(ad_lo_oe == 0, "R6 enable released", ad_lo_oe, 0);
      end
    end

    // R1: chip-select alone, then strobe alone
    mux_mode_i = 0; re0 = re_cnt; wl = 0;
    cs_n_i = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (wait_o) wl++; end
    cs_n_i = 1; rd_n_i = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (wait_o) wl++; end
    rd_n_i = 1;
    repeat (4) @(negedge clk);
    chk(wl == 0 && re_cnt == re0, "R1 no start without both", wl, 0);
    // R1: later-falling strobe starts the access
    addr_i = 9'h033; cs_n_i = 0;
    repeat (8) @(negedge clk);
    rd_n_i = 0;
    repeat (2) @(negedge clk);
    chk(wait_o == 0, "R1 not before sync", wait_o, 0);
    repeat (2) @(negedge clk);
    chk(wait_o == 1 && re_cnt == re0 + 1, "R1 start after strobe", {wait_o, re_cnt - re0}, 2'b11);

    // R6: enable drops combinationally on strobe release
    repeat (6) @(negedge clk);
    chk(ad_lo_oe == 1, "R6 enable while low", ad_lo_oe, 1);
    rd_n_i = 1; #1;
    chk(ad_lo_oe == 0, "R6 immediate release", ad_lo_oe, 0);
    cs_n_i = 1;
    repeat (6) @(negedge clk);

    // R3: transparent demultiplexed address
    mux_mode_i = 1; ad_lo_i = 8'h5A; ale_i = 1; #1;
    chk(demux_addr_o == 8'h5A, "R3 passes while high", demux_addr_o, 8'h5A);
    repeat (4) @(negedge clk);
    ale_i = 0;
    repeat (4) @(negedge clk);
    ad_lo_i = 8'hC3; #1;
    chk(demux_addr_o == 8'h5A, "R3 holds after fall", demux_addr_o, 8'h5A);
    ale_i = 1; #1;
    chk(demux_addr_o == 8'hC3, "R3 follows on rise", demux_addr_o, 8'hC3);
    ale_i = 0;
    repeat (4) @(negedge clk);
    mux_mode_i = 0; addr_i = 9'h0E7; #1;
    chk(demux_addr_o == 8'hE7, "R3 separate mode", demux_addr_o, 8'hE7);

    // R9: extended read after shadow read
    wide_mode_i = 1; addr_i = 9'h105; @(negedge clk);
    cs_n_i = 0; rd_n_i = 0;
    repeat (24) @(negedge clk);
    chk({ad_hi_o, ad_lo_o} == exp_mem[9'h105], "R9 first shadow read", {ad_hi_o, ad_lo_o}, exp_mem[9'h105]);
    addr_i = 9'h106;
    repeat (4) @(negedge clk);
    chk({ad_hi_o, ad_lo_o} == exp_mem[9'h106], "R9 extended fresh data", {ad_hi_o, ad_lo_o}, exp_mem[9'h106]);
    cs_n_i = 1; rd_n_i = 1;
    repeat (6) @(negedge clk);
    addr_i = 9'h007; @(negedge clk);
    cs_n_i = 0; rd_n_i = 0;
    repeat (24) @(negedge clk);
    addr_i = 9'h008;
    repeat (4) @(negedge clk);
    chk({ad_hi_o, ad_lo_o} == exp_mem[9'h007], "R9 no extension without shadow", {ad_hi_o, ad_lo_o}, exp_mem[9'h007]);
    cs_n_i = 1; rd_n_i = 1;
    repeat (6) @(negedge clk);

    finish_run();
  end
endmodule